// File: doc/BRIEF.md
# USB2 PHY Power Sequencer

This block brings a two-port USB2 PHY up and takes it down again in a fixed order. Each port has its own init and exit request pulse. For an init, the sequencer turns on the reference clock and then releases the shared power-on reset. It then issues one register write that enables the PHY clock, and finally releases the requesting port's UTMI reset. Each step waits its own settle interval, counted in pulses of a 1 µs tick strobe. When the last wait ends, the port is reported ready.

An exit reverses the order. The port's UTMI reset is raised at once. If no other port is still ready, the power-on reset is raised on the next cycle and the reference clock is switched off on the cycle after. Requests that arrive while a sequence is running are held until the sequencer returns to idle. Requests that would make no sense are dropped: an init for a port that is already ready, or an exit for a port that is not ready.

Top module: `usb_phy_powerseq`

## Requirements
- R1: After synchronous reset, `refclk_en` is 0, `por_rst` is 1, every `utmi_rst` bit is 1, `port_ready` is all zero and `wr_valid` is 0.
- R2: For an init that starts with the PHY off, `refclk_en` rises first. `por_rst` falls when exactly REF_TICKS (default 100) tick pulses have been sampled after that edge.
- R3: `wr_valid` rises when exactly POR_TICKS (default 300) tick pulses have been sampled after `por_rst` fell.
- R4: The write presents address 0x06, data 0x04 (bit 2 enables the PHY clock) and `wr_port` 0 whichever port asked for init. `wr_valid` stays high until it is sampled together with `wr_done` high, and it drops on that edge.
- R5: The requesting port's `utmi_rst` bit falls when exactly CLKEN_TICKS (default 2000) tick pulses have been sampled after the write was accepted.
- R6: That port's `port_ready` bit rises when exactly UTMI_TICKS (default 2000) tick pulses have been sampled after its `utmi_rst` fell. A ready port always has its UTMI reset low, `por_rst` low and `refclk_en` high.
- R7: An exit raises the port's `utmi_rst` and clears its `port_ready` on one edge. If no other port is ready, `por_rst` rises one cycle later and `refclk_en` falls one cycle after that. Otherwise both shared signals stay as they are.
- R8: An init for a ready port, or an exit for a port that is not ready, changes no output and issues no write.
- R9: A request that arrives while a sequence is running is held. It starts only after the running sequence has finished, so the first port is ready before the second port's UTMI reset is released.
- R10: When several held requests are eligible in the same idle cycle, exits are served before inits, and among requests of the same kind the lower port index goes first. Exits served back to back start on consecutive cycles.
- R11: An init while another port is ready runs the full sequence, including the write and every wait, without toggling `refclk_en` or `por_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_us | input | 1 | One-cycle strobe every microsecond |
| init_req | input | 2 | Per-port bring-up request pulse |
| exit_req | input | 2 | Per-port shutdown request pulse |
| wr_done | input | 1 | Write accepted by the PHY register port |
| refclk_en | output | 1 | Reference clock enable |
| por_rst | output | 1 | PHY power-on reset, active high |
| utmi_rst | output | 2 | Per-port UTMI reset, active high |
| port_ready | output | 2 | Per-port ready status |
| wr_valid | output | 1 | Register write request |
| wr_port | output | 1 | Port index of the register write |
| wr_addr | output | 8 | Register address of the write |
| wr_data | output | 8 | Write data |

## Verification
Two decisions can land on the same idle cycle: an exit for one port and an init for the other, or exits for both ports at once. The bench provokes the first case by pulsing `exit_req[0]` and `init_req[1]` on the same clock while port 0 is ready. It passes only if the full shutdown (UTMI reset, then power-on reset, then clock off on consecutive cycles) ends before the reference clock is turned back on for port 1. For the second case it pulses both exit bits together and checks, from cycle stamps, that port 0's UTMI reset rises one cycle before port 1's.

// File: rtl/usbseq_pkg.sv
// Package: shared types of the USB2 PHY power sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package usbseq_pkg;

    // Sequencer states; bring-up steps first, then shutdown steps.
    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_REF_WAIT,
        SQ_POR_WAIT,
        SQ_WRITE,
        SQ_CLK_WAIT,
        SQ_UTMI_WAIT,
        SQ_DOWN_POR,
        SQ_DOWN_REF
    } seq_state_t;

endpackage

// File: rtl/usbseq_tick_timer.sv
// Module: down-counter of microsecond ticks.
// Loading a count N makes 'expire' pulse together with the Nth tick
// sampled after the load edge. Assumes N >= 1 and that the caller
// only looks at 'expire' while a wait is in progress.
module usbseq_tick_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);

    logic [CNT_W-1:0] remain;

    // Count remaining ticks: reload on request, else step down on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (load)
            remain <= load_val;
        else if (tick && remain != '0)
            remain <= remain - 1'b1;
    end

    // The last tick of the wait ends it.
    assign expire = tick && (remain == CNT_W'(1));

    // Timer must not wrap below zero (supports R2, R3, R5, R6).
    a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && remain == '0 && !load) |=> (remain == '0));

endmodule

// File: rtl/usbseq_req_queue.sv
// Module: holds init and exit requests per port and picks the next one.
// Requests are captured as sticky bits. While the sequencer is idle,
// requests that make no sense (init of a ready port, exit of a port
// that is not ready) are dropped, and one eligible request is offered:
// exits before inits, lower port index first. Assumes the sequencer
// always takes the offered request while idle.
module usbseq_req_queue #(
    parameter int N_PORTS = 2,
    parameter int PORT_W  = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PORTS-1:0] init_req,
    input  logic [N_PORTS-1:0] exit_req,
    input  logic [N_PORTS-1:0] ready,
    input  logic               idle,
    output logic               pick_valid,
    output logic               pick_exit,
    output logic [PORT_W-1:0]  pick_port
);

    logic [N_PORTS-1:0] pend_init, pend_exit;
    logic [N_PORTS-1:0] elig_init, elig_exit;
    logic [N_PORTS-1:0] take_mask;

    // Choose the next request: lowest eligible init, overridden by lowest eligible exit.
    always_comb begin
        elig_init  = pend_init & ~ready;
        elig_exit  = pend_exit & ready;
        pick_valid = 1'b0;
        pick_exit  = 1'b0;
        pick_port  = '0;
        for (int i = N_PORTS - 1; i >= 0; i--) begin
            if (elig_init[i]) begin
                pick_valid = 1'b1;
                pick_port  = PORT_W'(i);
            end
        end
        for (int i = N_PORTS - 1; i >= 0; i--) begin
            if (elig_exit[i]) begin
                pick_valid = 1'b1;
                pick_exit  = 1'b1;
                pick_port  = PORT_W'(i);
            end
        end
    end

    // One-hot mask of the request taken this cycle.
    assign take_mask = (idle && pick_valid) ? (N_PORTS'(1) << pick_port) : '0;

    // Keep pending bits; while idle drop taken and meaningless requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_init <= '0;
            pend_exit <= '0;
        end else if (idle) begin
            pend_init <= (elig_init & ~(pick_exit ? '0 : take_mask)) | init_req;
            pend_exit <= (elig_exit & ~(pick_exit ? take_mask : '0)) | exit_req;
        end else begin
            pend_init <= pend_init | init_req;
            pend_exit <= pend_exit | exit_req;
        end
    end

    // An offered request is always meaningful for the port's current status (R8).
    a_r8_offer_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && pick_valid) |-> (ready[pick_port] == pick_exit));

    // An offered init only appears when no exit is eligible (R10).
    a_r10_exit_first: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && pick_valid && !pick_exit) |-> ((pend_exit & ready) == '0));

endmodule

// File: rtl/usbseq_fsm.sv
// Module: step controller of the power sequencer.
// Drives the reference clock enable, the shared power-on reset, the
// per-port UTMI resets and ready bits, the write request and the wait
// timer loads. Assumes each wait count is at least 1 and that the
// write port acknowledges with a one-cycle wr_done.
module usbseq_fsm
    import usbseq_pkg::*;
#(
    parameter int N_PORTS     = 2,
    parameter int PORT_W      = 1,
    parameter int CNT_W       = 12,
    parameter int REF_TICKS   = 100,
    parameter int POR_TICKS   = 300,
    parameter int CLKEN_TICKS = 2000,
    parameter int UTMI_TICKS  = 2000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pick_valid,
    input  logic               pick_exit,
    input  logic [PORT_W-1:0]  pick_port,
    input  logic               t_expire,
    input  logic               wr_done,
    output logic               idle,
    output logic               t_load,
    output logic [CNT_W-1:0]   t_val,
    output logic               refclk_en,
    output logic               por_rst,
    output logic [N_PORTS-1:0] utmi_rst,
    output logic [N_PORTS-1:0] ready,
    output logic               wr_valid
);

    seq_state_t        state;
    logic [PORT_W-1:0] cur_port;
    logic              others_ready;

    assign idle         = (state == SQ_IDLE);
    assign others_ready = |(ready & ~(N_PORTS'(1) << pick_port));

    // Select which wait to start on each step transition.
    always_comb begin
        t_load = 1'b0;
        t_val  = '0;
        case (state)
            SQ_IDLE: begin
                t_load = pick_valid && !pick_exit;
                t_val  = CNT_W'(REF_TICKS);
            end
            SQ_REF_WAIT: begin
                t_load = t_expire;
                t_val  = CNT_W'(POR_TICKS);
            end
            SQ_WRITE: begin
                t_load = wr_done;
                t_val  = CNT_W'(CLKEN_TICKS);
            end
            SQ_CLK_WAIT: begin
                t_load = t_expire;
                t_val  = CNT_W'(UTMI_TICKS);
            end
            default: begin
                t_load = 1'b0;
                t_val  = '0;
            end
        endcase
    end

    // Advance through bring-up or shutdown and update the control outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SQ_IDLE;
            cur_port  <= '0;
            refclk_en <= 1'b0;
            por_rst   <= 1'b1;
            utmi_rst  <= '1;
            ready     <= '0;
            wr_valid  <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (pick_valid) begin
                        cur_port <= pick_port;
                        if (pick_exit) begin
                            utmi_rst[pick_port] <= 1'b1;
                            ready[pick_port]    <= 1'b0;
                            state <= others_ready ? SQ_IDLE : SQ_DOWN_POR;
                        end else begin
                            refclk_en <= 1'b1;
                            state     <= SQ_REF_WAIT;
                        end
                    end
                end
                SQ_REF_WAIT: begin
                    if (t_expire) begin
                        por_rst <= 1'b0;
                        state   <= SQ_POR_WAIT;
                    end
                end
                SQ_POR_WAIT: begin
                    if (t_expire) begin
                        wr_valid <= 1'b1;
                        state    <= SQ_WRITE;
                    end
                end
                SQ_WRITE: begin
                    if (wr_done) begin
                        wr_valid <= 1'b0;
                        state    <= SQ_CLK_WAIT;
                    end
                end
                SQ_CLK_WAIT: begin
                    if (t_expire) begin
                        utmi_rst[cur_port] <= 1'b0;
                        state              <= SQ_UTMI_WAIT;
                    end
                end
                SQ_UTMI_WAIT: begin
                    if (t_expire) begin
                        ready[cur_port] <= 1'b1;
                        state           <= SQ_IDLE;
                    end
                end
                SQ_DOWN_POR: begin
                    por_rst <= 1'b1;
                    state   <= SQ_DOWN_REF;
                end
                SQ_DOWN_REF: begin
                    refclk_en <= 1'b0;
                    state     <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // The power-on reset is only released while the reference clock runs (R2).
    a_r2_por_needs_clk: assert property (@(posedge clk) disable iff (!rst_n)
        !por_rst |-> refclk_en);

    // A pending write holds its request until accepted (R4).
    a_r4_write_held: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_done) |=> wr_valid);

    // The power-on reset never rises while a port is still ready (R7).
    a_r7_por_after_ports: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(por_rst) |-> (ready == '0));

    // A ready port has its UTMI reset released and the shared supply up (R6).
    for (genvar p = 0; p < N_PORTS; p++) begin : g_port_chk
        a_r6_ready_clean: assert property (@(posedge clk) disable iff (!rst_n)
            ready[p] |-> (!utmi_rst[p] && !por_rst && refclk_en));
    end

endmodule

// File: rtl/usb_phy_powerseq.sv
// Module: top of the USB2 PHY power sequencer.
// Ties the request queue, the step controller and the tick timer
// together and presents the fixed PHY-clock-enable write. Assumes
// tick_us is a one-cycle strobe and that wr_done is a one-cycle
// acknowledge of wr_valid.
module usb_phy_powerseq #(
    parameter int         N_PORTS     = 2,
    parameter int         ADDR_W      = 8,
    parameter int         DATA_W      = 8,
    parameter int         REF_TICKS   = 100,
    parameter int         POR_TICKS   = 300,
    parameter int         CLKEN_TICKS = 2000,
    parameter int         UTMI_TICKS  = 2000,
    parameter logic [7:0] CLKEN_ADDR  = 8'h06,
    parameter logic [7:0] CLKEN_DATA  = 8'h04
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick_us,
    input  logic [N_PORTS-1:0]          init_req,
    input  logic [N_PORTS-1:0]          exit_req,
    input  logic                        wr_done,
    output logic                        refclk_en,
    output logic                        por_rst,
    output logic [N_PORTS-1:0]          utmi_rst,
    output logic [N_PORTS-1:0]          port_ready,
    output logic                        wr_valid,
    output logic [PORT_W_OUT-1:0]       wr_port,
    output logic [ADDR_W-1:0]           wr_addr,
    output logic [DATA_W-1:0]           wr_data
);

    localparam int PORT_W_OUT = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;
    localparam int MAX_A      = (REF_TICKS > POR_TICKS) ? REF_TICKS : POR_TICKS;
    localparam int MAX_B      = (CLKEN_TICKS > UTMI_TICKS) ? CLKEN_TICKS : UTMI_TICKS;
    localparam int MAX_T      = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W      = $clog2(MAX_T + 1);

    logic                  idle, pick_valid, pick_exit;
    logic [PORT_W_OUT-1:0] pick_port;
    logic                  t_load, t_expire;
    logic [CNT_W-1:0]      t_val;

    usbseq_req_queue #(.N_PORTS(N_PORTS), .PORT_W(PORT_W_OUT)) u_queue (
        .clk(clk), .rst_n(rst_n), .init_req(init_req), .exit_req(exit_req),
        .ready(port_ready), .idle(idle), .pick_valid(pick_valid),
        .pick_exit(pick_exit), .pick_port(pick_port)
    );

    usbseq_fsm #(
        .N_PORTS(N_PORTS), .PORT_W(PORT_W_OUT), .CNT_W(CNT_W),
        .REF_TICKS(REF_TICKS), .POR_TICKS(POR_TICKS),
        .CLKEN_TICKS(CLKEN_TICKS), .UTMI_TICKS(UTMI_TICKS)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .pick_valid(pick_valid), .pick_exit(pick_exit),
        .pick_port(pick_port), .t_expire(t_expire), .wr_done(wr_done),
        .idle(idle), .t_load(t_load), .t_val(t_val), .refclk_en(refclk_en),
        .por_rst(por_rst), .utmi_rst(utmi_rst), .ready(port_ready),
        .wr_valid(wr_valid)
    );

    usbseq_tick_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick_us), .load(t_load),
        .load_val(t_val), .expire(t_expire)
    );

    // The clock-enable register always lives behind port 0.
    assign wr_port = '0;
    assign wr_addr = ADDR_W'(CLKEN_ADDR);
    assign wr_data = DATA_W'(CLKEN_DATA);

endmodule

// File: tb/usb_phy_powerseq_tb_top.sv
module usb_phy_powerseq_tb_top;

    localparam int REF_T   = 100;
    localparam int POR_T   = 300;
    localparam int CLKEN_T = 2000;
    localparam int UTMI_T  = 2000;
    localparam int SETTLE  = 9400;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_us = 1'b0;
    logic [1:0] init_req = '0;
    logic [1:0] exit_req = '0;
    logic       wr_done = 1'b0;
    logic       refclk_en, por_rst, wr_valid;
    logic [1:0] utmi_rst, port_ready;
    logic [0:0] wr_port;
    logic [7:0] wr_addr, wr_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk; // 50 MHz

    usb_phy_powerseq dut_i (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .init_req(init_req),
        .exit_req(exit_req), .wr_done(wr_done), .refclk_en(refclk_en),
        .por_rst(por_rst), .utmi_rst(utmi_rst), .port_ready(port_ready),
        .wr_valid(wr_valid), .wr_port(wr_port), .wr_addr(wr_addr),
        .wr_data(wr_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Stamps in ticks (t_) and cycles (c_) of observed output edges.
    int  tcount = 0, cyc = 0;
    int  t_ref_on, t_por_off, t_wr_off;
    int  t_utmi_off [2];
    int  c_ref_on = 0, c_ref_off = 0, c_por_on = 0;
    int  c_utmi_on [2] = '{0, 0};
    int  c_utmi_off [2] = '{0, 0};
    int  c_ready_on [2] = '{0, 0};
    bit  por_fresh = 0;
    logic       p_ref = 1'b0, p_por = 1'b1, p_wv = 1'b0;
    logic [1:0] p_utmi = 2'b11, p_rdy = 2'b00;

    // Monitor at the falling edge, then advance the tick strobe (every 2 cycles).
    always @(negedge clk) begin
        cyc++;
        if (tick_us) tcount++;
        if (rst_n) begin
            if (refclk_en && !p_ref) begin t_ref_on = tcount; c_ref_on = cyc; end
            if (!refclk_en && p_ref) c_ref_off = cyc;
            if (!por_rst && p_por) begin
                t_por_off = tcount; por_fresh = 1;
                chk(tcount - t_ref_on == REF_T, "R2", "ticks clock-on to reset release",
                    tcount - t_ref_on, REF_T);
            end
            if (por_rst && !p_por) c_por_on = cyc;
            if (wr_valid && !p_wv && por_fresh) begin
                por_fresh = 0;
                chk(tcount - t_por_off == POR_T, "R3", "ticks reset release to write",
                    tcount - t_por_off, POR_T);
            end
            if (!wr_valid && p_wv) t_wr_off = tcount;
            for (int i = 0; i < 2; i++) begin
                if (!utmi_rst[i] && p_utmi[i]) begin
                    t_utmi_off[i] = tcount; c_utmi_off[i] = cyc;
                    chk(tcount - t_wr_off == CLKEN_T, "R5", "ticks write to UTMI release",
                        tcount - t_wr_off, CLKEN_T);
                end
                if (utmi_rst[i] && !p_utmi[i]) c_utmi_on[i] = cyc;
                if (port_ready[i] && !p_rdy[i]) begin
                    c_ready_on[i] = cyc;
                    chk(tcount - t_utmi_off[i] == UTMI_T, "R6", "ticks UTMI release to ready",
                        tcount - t_utmi_off[i], UTMI_T);
                end
            end
            tick_us <= ~tick_us;
        end
        p_ref = refclk_en; p_por = por_rst; p_wv = wr_valid;
        p_utmi = utmi_rst; p_rdy = port_ready;
    end

    // Write port model: accepts after wr_delay cycles, counts and checks writes.
    int n_writes = 0;
    int wr_delay = 5;
    int wcnt = 0;
    always @(negedge clk) begin
        if (wr_done) begin
            wr_done <= 1'b0;
            wcnt = 0;
            n_writes++;
            chk(wr_valid == 1'b0, "R4", "valid drops after accept", int'(wr_valid), 0);
        end else if (wr_valid) begin
            if (wcnt == wr_delay) begin
                wr_done <= 1'b1;
                chk(wr_addr == 8'h06, "R4", "write address", int'(wr_addr), 6);
                chk(wr_data == 8'h04, "R4", "write data", int'(wr_data), 4);
                chk(wr_port == 1'b0, "R4", "write port", int'(wr_port), 0);
            end else begin
                wcnt++;
            end
        end
    end

    task automatic pulse(input logic [1:0] ini, input logic [1:0] ext);
        @(negedge clk);
        init_req = ini; exit_req = ext;
        @(negedge clk);
        init_req = '0; exit_req = '0;
    endtask

    task automatic check_state(input logic [1:0] exp, input string req);
        chk(port_ready == exp, req, "port_ready", int'(port_ready), int'(exp));
        chk(refclk_en == (|exp), req, "refclk_en", int'(refclk_en), int'(|exp));
        chk(por_rst == ~(|exp), req, "por_rst", int'(por_rst), int'(~(|exp)));
        chk(utmi_rst == ~exp, req, "utmi_rst", int'(utmi_rst), int'(~exp));
    endtask

    // Vector: [5] ignored, [4] exit(1)/init(0), [3] port, [2] write expected, [1:0] ready after.
    localparam logic [5:0] VEC [0:8] = '{
        6'b000101, 6'b100001, 6'b001111, 6'b010010, 6'b110010,
        6'b011000, 6'b111000, 6'b001110, 6'b011000
    };

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset values
        chk(refclk_en == 1'b0, "R1", "refclk_en", int'(refclk_en), 0);
        chk(por_rst == 1'b1, "R1", "por_rst", int'(por_rst), 1);
        chk(utmi_rst == 2'b11, "R1", "utmi_rst", int'(utmi_rst), 3);
        chk(port_ready == 2'b00, "R1", "port_ready", int'(port_ready), 0);
        chk(wr_valid == 1'b0, "R1", "wr_valid", int'(wr_valid), 0);
        rst_n = 1'b1;

        for (int v = 0; v < 9; v++) begin
            automatic logic [5:0] e = VEC[v];
            automatic int w0 = n_writes;
            automatic logic [1:0] m = 2'b01 << e[3];
            automatic string tag = e[5] ? "R8" : (e[4] ? "R7" : "R6");
            pulse(e[4] ? 2'b00 : m, e[4] ? m : 2'b00);
            repeat (SETTLE) @(negedge clk);
            check_state(e[1:0], tag);
            chk(n_writes - w0 == int'(e[2]), e[5] ? "R8" : "R11", "writes issued",
                n_writes - w0, int'(e[2]));
        end

        // R9: second init arrives mid-sequence and waits its turn.
        begin
            automatic int w0 = n_writes;
            pulse(2'b01, 2'b00);
            repeat (1000) @(negedge clk);
            pulse(2'b10, 2'b00);
            repeat (2 * SETTLE) @(negedge clk);
            check_state(2'b11, "R9");
            chk(c_utmi_off[1] > c_ready_on[0], "R9", "port1 UTMI release after port0 ready",
                c_utmi_off[1], c_ready_on[0] + 1);
            chk(n_writes - w0 == 2, "R11", "writes for two inits", n_writes - w0, 2);
        end

        // R10: both exits in one cycle, lower index first, consecutive cycles.
        pulse(2'b00, 2'b11);
        repeat (50) @(negedge clk);
        check_state(2'b00, "R7");
        chk(c_utmi_on[1] - c_utmi_on[0] == 1, "R10", "exit spacing port0 to port1",
            c_utmi_on[1] - c_utmi_on[0], 1);
        chk(c_por_on - c_utmi_on[1] == 1, "R7", "cycles UTMI to power-on reset",
            c_por_on - c_utmi_on[1], 1);
        chk(c_ref_off - c_por_on == 1, "R7", "cycles reset to clock off",
            c_ref_off - c_por_on, 1);

        // R10: exit of port 0 and init of port 1 in the same cycle; exit wins.
        pulse(2'b01, 2'b00);
        repeat (SETTLE) @(negedge clk);
        pulse(2'b10, 2'b01);
        repeat (SETTLE + 100) @(negedge clk);
        check_state(2'b10, "R10");
        chk(c_ref_off - c_utmi_on[0] == 2, "R10", "shutdown completes first",
            c_ref_off - c_utmi_on[0], 2);
        chk(c_ref_on > c_ref_off, "R10", "clock back on after shutdown",
            c_ref_on, c_ref_off + 1);

        // R4/R11: long write stall while port 1 keeps the shared supply up.
        begin
            automatic int w0 = n_writes;
            automatic int por0 = c_por_on;
            automatic int ref0 = c_ref_off;
            wr_delay = 40;
            pulse(2'b01, 2'b00);
            repeat (SETTLE + 100) @(negedge clk);
            check_state(2'b11, "R11");
            chk(n_writes - w0 == 1, "R4", "stalled write accepted once", n_writes - w0, 1);
            chk(c_por_on == por0 && c_ref_off == ref0, "R11", "shared signals untouched",
                c_por_on, por0);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 190000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule